// File: doc/BRIEF.md
# I2C Control-Register Target with Command Execution

This block is the control-register target of a serial memory device on a two-wire I2C bus. A master addresses it and writes a register pointer. It then either writes data bytes or switches to reading with a repeated START. The register space holds a fixed 32-bit identification word at pointer 0x00 to 0x03, most significant byte first. Writing one byte to the command register at 0xAA selects an internal operation. The operation is launched when the master ends the transaction with a STOP.

While an operation runs, the device answers none of its three target addresses. This block does not acknowledge its own address during that time. It also masks the open-drain pull requests coming from the memory and clock targets that share the SDA pad (`peer_oe`), so that every target address goes unacknowledged. SCL and SDA are resynchronised inside the block. The block pulls SDA low through an output enable and never stretches the clock.

Top module: `i2c_ctrl_target`

## Requirements
- R1: After reset, `sda_oe`, `busy` and `op_start` are all 0.
- R2: The 7-bit target address is binary 0011, then `strap_a2`, then `strap_a1`, then a don't-care bit. Bit 0 of the address byte is R/W, with 0 meaning write. The address byte is ACKed only on a match while not busy. Any other address, including 1010xxx, gets no ACK.
- R3: Reads at pointers 0x00 to 0x03 return the ID word MSB first. The ID word holds a manufacturer code in bits 31..21 (0x0A3), a product code in bits 20..7 (0x1C47), a density code in bits 6..3 (0x5) and a die revision in bits 2..0 (0). Other pointers read 0x00.
- R4: Data bytes written to any pointer other than 0xAA are ACKed and change nothing; the ID reads back unchanged.
- R5: Writing pointer 0xAA and then a valid code ACKs both bytes. After the STOP, `op_start` pulses for exactly one cycle with `op_sel` set to 0 for code 0x3C, 1 for 0xC3 and 2 for 0x5A.
- R6: `busy` rises with `op_start` and stays high for exactly 300, 500 or 150 clock cycles for `op_sel` 0, 1 or 2.
- R7: While `busy` is high, the control address is NACKed and `peer_oe` is masked, so `sda_oe` stays 0. While idle, `peer_oe` passes through to `sda_oe`.
- R8: An unknown code written to 0xAA is ACKed and starts no operation: no `op_start` and no `busy`.
- R9: After a data byte is written to 0xAA, the pointer is 0x00, so a current-address read returns ID byte 3 (bits 31..24).
- R10: The pointer advances by one per data byte, read or written, and wraps from 0xFF to 0x00.
- R11: START and STOP are SDA falling and rising edges while SCL is high. A repeated START in the middle of a byte restarts address framing.
- R12: The block changes its own SDA pull only while SCL is low.
- R13: A command byte launches only on STOP. A repeated START after it cancels the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| strap_a2 | input | 1 | Address strap, address bit 3 |
| strap_a1 | input | 1 | Address strap, address bit 2 |
| peer_oe | input | 1 | SDA pull request from the memory and clock targets |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Internal operation in progress |
| op_start | output | 1 | One-cycle launch pulse for an operation |
| op_sel | output | 2 | Index of the launched operation |

## Verification
The bench runs each command and counts the exact busy length, so an off-by-one timer shows up as 299 or 301 cycles. It addresses the block during a long operation and asserts the peer pull request there. A design that kept acknowledging, or passed the memory target's ACK through, would show up at `sda_oe`. It writes an unknown code, and it also cancels a valid code with a repeated START. A decoder that launched on either would raise `op_start`. Current-address reads after a command write, and a read across pointer 0xFF, expose a pointer that misses the reset to 0x00 or saturates instead of wrapping. A repeated START cut into a half-sent byte checks that the framing restarts.

// File: rtl/ict_pkg.sv
package ict_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RX,
      PH_ACK,
      PH_TX,
      PH_MACK
   } ict_phase_t;

   typedef enum logic [1:0] {
      RL_ADDR,
      RL_REG,
      RL_DATA
   } ict_role_t;

   localparam int unsigned ICT_ID_BYTES = 4;
endpackage

// File: rtl/ict_sync.sv
module ict_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_p;
   logic              sda_p;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff <= 1'b1;
               sda_ff <= 1'b1;
            end else begin
               scl_ff <= scl_i;
               sda_ff <= sda_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff <= '1;
               sda_ff <= '1;
            end else begin
               scl_ff <= {scl_ff[STAGES-2:0], scl_i};
               sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_ff[STAGES-1];
         sda_p <= sda_ff[STAGES-1];
      end
   end

   assign scl_s    = scl_ff[STAGES-1];
   assign sda_s    = sda_ff[STAGES-1];
   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/ict_id_rom.sv
module ict_id_rom import ict_pkg::*; #(
   parameter logic [7:0]  BASE    = 8'h00,
   parameter logic [31:0] ID_WORD = 32'h0
) (
   input  logic [7:0] addr,
   output logic [7:0] data
);
   logic [7:0] id_b [ICT_ID_BYTES];
   logic [7:0] off;

   generate
      for (genvar j = 0; j < ICT_ID_BYTES; j++) begin : g_byte
         assign id_b[j] = ID_WORD[31-8*j -: 8];
      end
   endgenerate

   assign off  = addr - BASE;
   assign data = (off < 8'(ICT_ID_BYTES)) ? id_b[off[1:0]] : 8'h00;
endmodule

// File: rtl/ict_cmd_timer.sv
module ict_cmd_timer #(
   parameter int unsigned          NUM_CMDS   = 3,
   parameter int unsigned          CNT_W      = 16,
   parameter logic [NUM_CMDS*8-1:0]     CMD_CODES  = {8'h5A, 8'hC3, 8'h3C},
   parameter logic [NUM_CMDS*CNT_W-1:0] CMD_CYCLES = {16'd150, 16'd500, 16'd300},
   localparam int unsigned         SEL_W      = (NUM_CMDS > 1) ? $clog2(NUM_CMDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_byte,
   input  logic             cancel,
   input  logic             launch,
   output logic             busy,
   output logic             op_start,
   output logic [SEL_W-1:0] op_sel
);
   logic [NUM_CMDS-1:0] hit;
   logic [SEL_W-1:0]    enc;
   logic                pend_valid;
   logic [SEL_W-1:0]    pend_sel;
   logic [CNT_W-1:0]    cnt;

   generate
      for (genvar i = 0; i < NUM_CMDS; i++) begin : g_dec
         assign hit[i] = (wr_byte == CMD_CODES[i*8 +: 8]);
      end
   endgenerate

   always_comb begin
      enc = '0;
      for (int i = NUM_CMDS - 1; i >= 0; i--) begin
         if (hit[i]) enc = SEL_W'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_valid <= 1'b0;
         pend_sel   <= '0;
         busy       <= 1'b0;
         cnt        <= '0;
         op_start   <= 1'b0;
         op_sel     <= '0;
      end else begin
         op_start <= 1'b0;
         if (wr_en) begin
            pend_valid <= |hit;
            pend_sel   <= enc;
         end else if (cancel) begin
            pend_valid <= 1'b0;
         end
         if (launch && pend_valid && !busy) begin
            busy       <= 1'b1;
            cnt        <= CMD_CYCLES[int'(pend_sel)*CNT_W +: CNT_W];
            op_start   <= 1'b1;
            op_sel     <= pend_sel;
            pend_valid <= 1'b0;
         end else if (busy) begin
            if (cnt == CNT_W'(1)) busy <= 1'b0;
            else                  cnt  <= cnt - CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/i2c_ctrl_target.sv
module i2c_ctrl_target import ict_pkg::*; #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [3:0]  CTRL_PREFIX = 4'b0011,
   parameter logic [7:0]  CMD_REG     = 8'hAA,
   parameter logic [7:0]  ID_BASE     = 8'h00,
   parameter logic [10:0] MFR_ID      = 11'h0A3,
   parameter logic [13:0] PROD_ID     = 14'h1C47,
   parameter logic [3:0]  DENS_ID     = 4'h5,
   parameter logic [2:0]  DIE_REV     = 3'h0,
   parameter int unsigned NUM_CMDS    = 3,
   parameter int unsigned CNT_W       = 16,
   parameter logic [NUM_CMDS*8-1:0]     CMD_CODES  = {8'h5A, 8'hC3, 8'h3C},
   parameter logic [NUM_CMDS*CNT_W-1:0] CMD_CYCLES = {16'd150, 16'd500, 16'd300},
   localparam int unsigned SEL_W = (NUM_CMDS > 1) ? $clog2(NUM_CMDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   input  logic             strap_a2,
   input  logic             strap_a1,
   input  logic             peer_oe,
   output logic             sda_oe,
   output logic             busy,
   output logic             op_start,
   output logic [SEL_W-1:0] op_sel
);
   localparam logic [31:0] ID_WORD = {MFR_ID, PROD_ID, DENS_ID, DIE_REV};

   initial begin
      if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
      if (NUM_CMDS < 3)    $error("NUM_CMDS must be at least 3");
      if (CNT_W < 2)       $error("CNT_W must be at least 2");
      for (int k = 0; k < NUM_CMDS; k++) begin
         if (CMD_CYCLES[k*CNT_W +: CNT_W] == '0) $error("busy time must be nonzero");
      end
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
   logic [7:0] rd_byte;
   logic       cmd_wr;
   logic [7:0] cmd_wbyte;

   ict_phase_t phase;
   ict_role_t  role;
   logic       rd_mode;
   logic [2:0] bitcnt;
   logic [6:0] shreg;
   logic [6:0] tx;
   logic       ack_go;
   logic       ack_drv;
   logic [1:0] mstage;
   logic       own_oe;
   logic [7:0] ptr;
   logic [7:0] rx_byte;
   logic       addr_hit;

   ict_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   ict_id_rom #(.BASE(ID_BASE), .ID_WORD(ID_WORD)) u_rom (
      .addr (ptr),
      .data (rd_byte)
   );

   ict_cmd_timer #(
      .NUM_CMDS   (NUM_CMDS),
      .CNT_W      (CNT_W),
      .CMD_CODES  (CMD_CODES),
      .CMD_CYCLES (CMD_CYCLES)
   ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cmd_wr),
      .wr_byte  (cmd_wbyte),
      .cancel   (start_ev),
      .launch   (stop_ev),
      .busy     (busy),
      .op_start (op_start),
      .op_sel   (op_sel)
   );

   assign rx_byte  = {shreg, sda_s};
   assign addr_hit = (rx_byte[7:4] == CTRL_PREFIX) && (rx_byte[3] == strap_a2)
                     && (rx_byte[2] == strap_a1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         role      <= RL_ADDR;
         rd_mode   <= 1'b0;
         bitcnt    <= '0;
         shreg     <= '0;
         tx        <= '0;
         ack_go    <= 1'b0;
         ack_drv   <= 1'b0;
         mstage    <= '0;
         own_oe    <= 1'b0;
         ptr       <= '0;
         cmd_wr    <= 1'b0;
         cmd_wbyte <= '0;
      end else begin
         cmd_wr <= 1'b0;
         if (start_ev) begin
            phase   <= PH_RX;
            role    <= RL_ADDR;
            rd_mode <= 1'b0;
            bitcnt  <= '0;
            own_oe  <= 1'b0;
         end else if (stop_ev) begin
            phase  <= PH_IDLE;
            own_oe <= 1'b0;
         end else begin
            unique case (phase)
               PH_RX: if (scl_rise) begin
                  shreg  <= rx_byte[6:0];
                  bitcnt <= bitcnt + 3'd1;
                  if (bitcnt == 3'd7) begin
                     phase   <= PH_ACK;
                     ack_drv <= 1'b0;
                     unique case (role)
                        RL_ADDR: begin
                           ack_go  <= addr_hit && !busy;
                           rd_mode <= rx_byte[0];
                           role    <= RL_REG;
                        end
                        RL_REG: begin
                           ack_go <= 1'b1;
                           ptr    <= rx_byte;
                           role   <= RL_DATA;
                        end
                        default: begin
                           ack_go <= 1'b1;
                           if (ptr == CMD_REG) begin
                              ptr       <= '0;
                              cmd_wr    <= 1'b1;
                              cmd_wbyte <= rx_byte;
                           end else begin
                              ptr <= ptr + 8'd1;
                           end
                        end
                     endcase
                  end
               end
               PH_ACK: if (scl_fall) begin
                  if (!ack_drv) begin
                     if (ack_go) begin
                        own_oe  <= 1'b1;
                        ack_drv <= 1'b1;
                     end else begin
                        phase <= PH_IDLE;
                     end
                  end else begin
                     ack_drv <= 1'b0;
                     bitcnt  <= '0;
                     if (rd_mode) begin
                        phase  <= PH_TX;
                        tx     <= rd_byte[6:0];
                        own_oe <= ~rd_byte[7];
                     end else begin
                        phase  <= PH_RX;
                        own_oe <= 1'b0;
                     end
                  end
               end
               PH_TX: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 3'd1;
                     if (bitcnt == 3'd7) begin
                        phase  <= PH_MACK;
                        mstage <= 2'd0;
                        ptr    <= ptr + 8'd1;
                     end
                  end else if (scl_fall) begin
                     own_oe <= ~tx[6];
                     tx     <= {tx[5:0], 1'b0};
                  end
               end
               PH_MACK: begin
                  if (mstage == 2'd0 && scl_fall) begin
                     own_oe <= 1'b0;
                     mstage <= 2'd1;
                  end else if (mstage == 2'd1 && scl_rise) begin
                     if (!sda_s) mstage <= 2'd2;
                     else        phase  <= PH_IDLE;
                  end else if (mstage == 2'd2 && scl_fall) begin
                     phase  <= PH_TX;
                     bitcnt <= '0;
                     tx     <= rd_byte[6:0];
                     own_oe <= ~rd_byte[7];
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe = own_oe | (peer_oe & ~busy);
endmodule

// File: rtl/ict_checker.sv
module ict_checker (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic own_oe,
   input logic sda_oe,
   input logic busy,
   input logic op_start
);
   // R12: own pull moves only with SCL low
   a_r12_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(own_oe) |-> !scl_i);

   // R7: nothing reaches the pad during an operation
   a_r7_busy_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe);

   // R5: launch pulse is one cycle wide
   a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |=> !op_start);

   // R6: busy accompanies the launch
   a_r6_busy_with_start: assert property (@(posedge clk) disable iff (!rst_n)
      op_start |-> busy);

   // R6: no relaunch while an operation runs
   a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !op_start |=> !op_start);
endmodule

bind i2c_ctrl_target ict_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_i    (scl_i),
   .own_oe   (own_oe),
   .sda_oe   (sda_oe),
   .busy     (busy),
   .op_start (op_start)
);

// File: tb/i2c_ctrl_target_tb.sv
module i2c_ctrl_target_tb;
   localparam int Q = 10;
   localparam logic [31:0] EXP_ID = {11'h0A3, 14'h1C47, 4'h5, 3'h0};
   localparam logic [6:0]  CTRL_A = {4'b0011, 1'b1, 1'b0, 1'b0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic peer_oe = 1'b0;
   logic sda_line;
   logic sda_oe, busy, op_start;
   logic [1:0] op_sel;
   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #5 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   i2c_ctrl_target u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_m),
      .sda_i    (sda_line),
      .strap_a2 (1'b1),
      .strap_a1 (1'b0),
      .peer_oe  (peer_oe),
      .sda_oe   (sda_oe),
      .busy     (busy),
      .op_start (op_start),
      .op_sel   (op_sel)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] id_byte(input int k);
      return EXP_ID[31-8*k -: 8];
   endfunction

   task automatic bus_start;
      sda_m = 1'b1; scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_rstart;
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1;
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; tick(Q);
      scl_m = 1'b1; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q/2);
      ack = ~sda_line; tick(Q/2);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b);
      b = '0;
      for (int i = 0; i < 8; i++) begin
         sda_m = 1'b1; tick(Q);
         scl_m = 1'b1; tick(Q/2);
         b = {b[6:0], sda_line}; tick(Q/2);
         scl_m = 1'b0;
      end
      tick(Q);
      sda_m = ~mack; tick(Q);
      scl_m = 1'b1; tick(Q);
      scl_m = 1'b0; tick(Q);
      sda_m = 1'b1;
   endtask

   task automatic set_ptr(input logic [7:0] p);
      logic a;
      bus_start;
      send_byte({CTRL_A, 1'b0}, a);
      send_byte(p, a);
   endtask

   task automatic t_reset;
      chk("R1 sda_oe", 32'(sda_oe), 0);
      chk("R1 busy", 32'(busy), 0);
      chk("R1 op_start", 32'(op_start), 0);
   endtask

   task automatic t_address;
      logic a;
      bus_start; send_byte({CTRL_A, 1'b0}, a); bus_stop; tick(Q);
      chk("R2 own address ack", 32'(a), 1);
      bus_start; send_byte({CTRL_A | 7'b0000001, 1'b0}, a); bus_stop; tick(Q);
      chk("R2 dont-care bit set ack", 32'(a), 1);
      bus_start; send_byte({4'b0011, 1'b0, 1'b1, 1'b0, 1'b0}, a); bus_stop; tick(Q);
      chk("R2 wrong straps nack", 32'(a), 0);
      bus_start; send_byte({4'b1010, 1'b1, 1'b0, 1'b0, 1'b0}, a); bus_stop; tick(Q);
      chk("R2 memory target not answered", 32'(a), 0);
   endtask

   task automatic t_id_read;
      logic a;
      logic [7:0] b;
      set_ptr(8'h00);
      bus_rstart;
      send_byte({CTRL_A, 1'b1}, a);
      chk("R3 read address ack", 32'(a), 1);
      for (int k = 0; k < 4; k++) begin
         recv_byte(k != 3, b);
         chk("R3 id byte", 32'(b), 32'(id_byte(k)));
      end
      bus_stop; tick(Q);
   endtask

   task automatic t_id_write;
      logic a;
      logic [7:0] b;
      set_ptr(8'h01);
      send_byte(8'hFF, a);
      chk("R4 write to id acked", 32'(a), 1);
      send_byte(8'h00, a);
      bus_stop; tick(Q);
      set_ptr(8'h01);
      bus_rstart; send_byte({CTRL_A, 1'b1}, a);
      recv_byte(1'b1, b);
      chk("R4 id byte 1 unchanged", 32'(b), 32'(id_byte(1)));
      recv_byte(1'b0, b);
      chk("R4 id byte 2 unchanged", 32'(b), 32'(id_byte(2)));
      bus_stop; tick(Q);
   endtask

   task automatic t_wrap;
      logic a;
      logic [7:0] b;
      set_ptr(8'hFF);
      bus_rstart; send_byte({CTRL_A, 1'b1}, a);
      recv_byte(1'b1, b);
      chk("R10 unmapped 0xFF reads zero", 32'(b), 0);
      recv_byte(1'b0, b);
      chk("R10 pointer wrapped to 0x00", 32'(b), 32'(id_byte(0)));
      bus_stop; tick(Q);
   endtask

   task automatic t_rstart;
      logic a;
      logic [7:0] b;
      bus_start;
      send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
      bus_rstart;
      send_byte({CTRL_A, 1'b0}, a);
      chk("R11 address after cut byte acked", 32'(a), 1);
      send_byte(8'h02, a);
      bus_rstart; send_byte({CTRL_A, 1'b1}, a);
      recv_byte(1'b0, b);
      chk("R11 framing restarted", 32'(b), 32'(id_byte(2)));
      bus_stop; tick(Q);
   endtask

   task automatic current_read(output logic [7:0] b);
      logic a;
      bus_start; send_byte({CTRL_A, 1'b1}, a);
      recv_byte(1'b0, b);
      bus_stop; tick(Q);
   endtask

   task automatic t_cmd(input logic [7:0] code, input int idx, input int cyc, input bit probe);
      logic a1, a2, a;
      int n, w;
      logic [7:0] b;
      set_ptr(8'hAA);
      send_byte(code, a2);
      a1 = 1'b1;
      chk("R5 command byte acked", 32'(a2 & a1), 1);
      bus_stop;
      w = 0;
      while (!op_start && w < 40) begin tick(1); w++; end
      chk("R5 op_start seen", 32'(op_start), 1);
      chk("R5 op_sel", 32'(op_sel), 32'(idx));
      n = 0;
      if (probe) begin
         peer_oe = 1'b1; tick(1); n++;
         chk("R7 peer pull masked while busy", 32'(sda_oe), 0);
         peer_oe = 1'b0;
         tick(Q - 1); n += Q - 1;
         bus_start; send_byte({CTRL_A, 1'b0}, a); bus_stop;
         n += 3*Q + 9*3*Q + 2*Q;
         chk("R7 control address nacked while busy", 32'(a), 0);
         while (busy && n < 2000) begin n++; tick(1); end
      end else begin
         while (busy && n < 2000) begin n++; tick(1); end
         chk("R6 busy length", 32'(n), 32'(cyc));
      end
      tick(Q);
      current_read(b);
      chk("R9 pointer at 0x00 after command", 32'(b), 32'(id_byte(0)));
   endtask

   task automatic t_invalid;
      logic a;
      bit seen;
      logic [7:0] b;
      set_ptr(8'hAA);
      send_byte(8'h77, a);
      chk("R8 unknown code acked", 32'(a), 1);
      bus_stop;
      seen = 0;
      for (int i = 0; i < 40; i++) begin
         if (op_start || busy) seen = 1;
         tick(1);
      end
      chk("R8 unknown code no operation", 32'(seen), 0);
      current_read(b);
      chk("R9 pointer at 0x00 after unknown code", 32'(b), 32'(id_byte(0)));
      set_ptr(8'hAA);
      send_byte(8'h3C, a);
      bus_rstart; send_byte({CTRL_A, 1'b0}, a);
      bus_stop;
      seen = 0;
      for (int i = 0; i < 40; i++) begin
         if (op_start || busy) seen = 1;
         tick(1);
      end
      chk("R13 repeated start cancels command", 32'(seen), 0);
   endtask

   task automatic t_peer_idle;
      peer_oe = 1'b1; tick(1);
      chk("R7 peer pull passes when idle", 32'(sda_oe), 1);
      peer_oe = 1'b0; tick(1);
      chk("R7 pad released when idle", 32'(sda_oe), 0);
   endtask

   task automatic report;
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      tick(3);
      t_reset;
      rst_n = 1'b1;
      tick(5);
      t_reset;
      t_address;
      t_id_read;
      t_id_write;
      t_wrap;
      t_rstart;
      t_peer_idle;
      t_cmd(8'h3C, 0, 300, 1'b0);
      t_cmd(8'hC3, 1, 500, 1'b1);
      t_cmd(8'h5A, 2, 150, 1'b0);
      t_invalid;
      report;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      report;
   end
endmodule